// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Global Enables

This block gathers interrupt requests for a small microcontroller core. It latches the requests and picks the one to service. Three exception sources can never be masked: non-maskable, unimplemented opcode and trap. Beside them are two external interrupts and a parameterised number of peripheral sources. Every request is captured on its rising edge into a pending flag. The flag stays set until the unit that services the source acknowledges it.

Maskable sources pass through a per-source mask register. A per-source redirect register can send a request to a hardware transaction-server engine instead of a CPU vector. The CPU path is gated by a global interrupt enable flag, and the server path by a separate global server enable flag. Each flag has its own pair of set and clear strobes. The first external interrupt takes either a dedicated pin or a general port pin as its source. The second external interrupt always uses the dedicated pin. It is suppressed whenever the dedicated pin already feeds the first one, so a single edge is not serviced twice.

Each path presents the lowest-numbered eligible source as an index, with a valid flag and an acknowledge input.

Top module: `intc_prio`

## Requirements
- R1: After reset, `irq_req` and `srv_req` are low, both registers read 0, and both global flags are clear.
- R2: Source ids 0 (non-maskable), 1 (unimplemented opcode) and 2 (trap) reach `irq_req`/`irq_id` whenever they are pending, whatever the mask, redirect and global flag state.
- R3: A maskable source with id k (k ≥ 3) is presented on the CPU path only when it is pending, mask bit k-3 is 1, and the global interrupt enable is set.
- R4: `gie_set` sets the global interrupt enable and `gie_clr` clears it, one cycle after the strobe. When both strobes arrive together, the clear wins.
- R5: With `reg_we` high, `reg_wdata` is written to the mask register when `reg_addr`=0 and to the redirect register when `reg_addr`=1. `reg_rdata` shows the register that `reg_addr` selects, with bit j belonging to source id j+3.
- R6: A source becomes pending on a 0-to-1 change of its input. Holding the input high does not create a second request, and the flag stays set until it is acknowledged.
- R7: `irq_ack` while `irq_req` is high clears the pending flag of `irq_id`, and `srv_ack` does the same for `srv_id`. A new rising edge of the same source in that cycle keeps the flag set.
- R8: Source id 3 follows `ext_pin` when `ext_sel`=0 and `port_pin` when `ext_sel`=1. It triggers on a rising edge of the selected signal.
- R9: Source id 4 triggers on rising edges of `ext_pin`. While `ext_sel`=0 it is presented on neither path.
- R10: When the server enable is set, a pending, unmasked source whose redirect bit is 1 is presented on `srv_req`/`srv_id` and not on the CPU path. `tse_set` and `tse_clr` set and clear the server enable, and the clear wins.
- R11: While the server enable is clear, a redirected source falls back to the CPU path under the R3 rules.
- R12: On each path, the lowest-numbered eligible source is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nmi_req | input | 1 | Non-maskable request (id 0) |
| undef_req | input | 1 | Unimplemented-opcode request (id 1) |
| trap_req | input | 1 | Trap request (id 2) |
| per_req | input | NPER | Peripheral requests (ids 5 and up) |
| ext_pin | input | 1 | Dedicated external interrupt pin |
| port_pin | input | 1 | General port pin usable as external source |
| ext_sel | input | 1 | 0: dedicated pin drives id 3, 1: port pin drives id 3 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0: mask register, 1: redirect register |
| reg_wdata | input | NPER+2 | Register write data |
| reg_rdata | output | NPER+2 | Selected register contents |
| gie_set | input | 1 | Set global interrupt enable |
| gie_clr | input | 1 | Clear global interrupt enable |
| tse_set | input | 1 | Set global server enable |
| tse_clr | input | 1 | Clear global server enable |
| irq_req | output | 1 | CPU request valid |
| irq_id | output | $clog2(NPER+5) | CPU source index |
| irq_ack | input | 1 | CPU acknowledge |
| srv_req | output | 1 | Transaction-server request valid |
| srv_id | output | $clog2(NPER+5) | Server source index |
| srv_ack | input | 1 | Server acknowledge |

## Verification
The bench builds the block with NPER=8, which gives 13 sources and a 4-bit index. At that size the random stimulus regularly has several sources pending at once across all three classes. It also reaches every combination of mask, redirect and both global flags. Directed steps cover the strobe collisions, the edge-versus-acknowledge collision and the selection of the external pin.

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int NPER = 8,
  localparam int NMASK = NPER + 2,
  localparam int NSRC = NPER + 5,
  localparam int ID_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_req,
  input  logic             undef_req,
  input  logic             trap_req,
  input  logic [NPER-1:0]  per_req,
  input  logic             ext_pin,
  input  logic             port_pin,
  input  logic             ext_sel,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [NMASK-1:0] reg_wdata,
  output logic [NMASK-1:0] reg_rdata,
  input  logic             gie_set,
  input  logic             gie_clr,
  input  logic             tse_set,
  input  logic             tse_clr,
  output logic             irq_req,
  output logic [ID_W-1:0]  irq_id,
  input  logic             irq_ack,
  output logic             srv_req,
  output logic [ID_W-1:0]  srv_id,
  input  logic             srv_ack
);
  logic [NSRC-1:0]  raw, prev, pend, rise, clr;
  logic [NMASK-1:0] mask, redir, eff_mask, cpu_m, srv_m;
  logic             gie, tse;
  logic [NSRC-1:0]  cpu_c, srv_c;

  function automatic logic [ID_W-1:0] lowest(input logic [NSRC-1:0] v);
    logic [ID_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) r = ID_W'(i);
    return r;
  endfunction

  assign raw  = {per_req, ext_pin, (ext_sel ? port_pin : ext_pin), trap_req, undef_req, nmi_req};
  assign rise = raw & ~prev;

  assign eff_mask = mask & ~(ext_sel ? {NMASK{1'b0}} : NMASK'(2));
  assign cpu_m = pend[NSRC-1:3] & eff_mask & {NMASK{gie}} & ~(redir & {NMASK{tse}});
  assign srv_m = pend[NSRC-1:3] & eff_mask & redir & {NMASK{tse}};
  assign cpu_c = {cpu_m, pend[2:0]};
  assign srv_c = {srv_m, 3'b000};

  assign irq_req = |cpu_c;
  assign irq_id  = lowest(cpu_c);
  assign srv_req = |srv_c;
  assign srv_id  = lowest(srv_c);

  assign reg_rdata = reg_addr ? redir : mask;

  always_comb begin
    clr = '0;
    if (irq_req && irq_ack) clr[irq_id] = 1'b1;
    if (srv_req && srv_ack) clr[srv_id] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= '0;
      pend  <= '0;
      mask  <= '0;
      redir <= '0;
      gie   <= 1'b0;
      tse   <= 1'b0;
    end else begin
      prev <= raw;
      pend <= (pend & ~clr) | rise;
      if (reg_we && !reg_addr) mask  <= reg_wdata;
      if (reg_we &&  reg_addr) redir <= reg_wdata;
      if (gie_clr)      gie <= 1'b0;
      else if (gie_set) gie <= 1'b1;
      if (tse_clr)      tse <= 1'b0;
      else if (tse_set) tse <= 1'b1;
    end
  end

  assert_nmi_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] |-> (irq_req && irq_id == '0));

  assert_gie_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie && irq_req) |-> (irq_id < ID_W'(3)));

  assert_gie_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !gie);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && irq_id == '0 && !nmi_req) |=> !pend[0]);

  assert_ext1_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_sel |-> !((irq_req && irq_id == ID_W'(4)) || (srv_req && srv_id == ID_W'(4))));

  assert_paths_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && srv_req) |-> (irq_id != srv_id));

  assert_srv_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srv_req |-> tse);
endmodule

// File: tb/tb_intc_prio.sv
`timescale 1ns/1ps
module tb_intc_prio;
  localparam int NPER = 8;
  localparam int NMASK = NPER + 2;
  localparam int NSRC = NPER + 5;
  localparam int ID_W = $clog2(NSRC);

  logic clk = 0, rst_n = 0;
  logic nmi_req = 0, undef_req = 0, trap_req = 0, ext_pin = 0, port_pin = 0, ext_sel = 0;
  logic [NPER-1:0] per_req = '0;
  logic reg_we = 0, reg_addr = 0;
  logic [NMASK-1:0] reg_wdata = '0, reg_rdata;
  logic gie_set = 0, gie_clr = 0, tse_set = 0, tse_clr = 0;
  logic irq_req, srv_req, irq_ack = 0, srv_ack = 0;
  logic [ID_W-1:0] irq_id, srv_id;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [NSRC-1:0] m_pend = '0, m_prev = '0;
  logic [NMASK-1:0] m_mask = '0, m_redir = '0;
  logic m_gie = 0, m_tse = 0;
  logic e_irq, e_srv;
  logic [ID_W-1:0] e_id, e_sid;

  always #2.5 clk = ~clk;

  intc_prio #(.NPER(NPER)) dut (.*);

  function automatic logic [ID_W-1:0] first_one(input logic [NSRC-1:0] v);
    for (int i = 0; i < NSRC; i++) if (v[i]) return ID_W'(i);
    return '0;
  endfunction

  task automatic calc_exp();
    logic [NSRC-1:0] c, s;
    for (int i = 0; i < NSRC; i++) begin
      logic el;
      int k;
      k = i - 3;
      if (i < 3) begin
        c[i] = m_pend[i];
        s[i] = 1'b0;
      end else begin
        el = m_pend[i] && m_mask[k] && !(i == 4 && !ext_sel);
        s[i] = el && m_tse && m_redir[k];
        c[i] = el && m_gie && !s[i];
      end
    end
    e_irq = |c; e_id = first_one(c);
    e_srv = |s; e_sid = first_one(s);
  endtask

  task automatic fail_line(string tag, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  task automatic cmp(string tag);
    #0.5;
    calc_exp();
    checks++;
    if (irq_req !== e_irq) fail_line(tag, "irq_req", irq_req, e_irq);
    else if (e_irq && irq_id !== e_id) fail_line(tag, "irq_id", irq_id, e_id);
    else if (srv_req !== e_srv) fail_line(tag, "srv_req", srv_req, e_srv);
    else if (e_srv && srv_id !== e_sid) fail_line(tag, "srv_id", srv_id, e_sid);
    else if (reg_rdata !== (reg_addr ? m_redir : m_mask))
      fail_line(tag, "reg_rdata", reg_rdata, reg_addr ? m_redir : m_mask);
  endtask

  task automatic cycle();
    logic [NSRC-1:0] raw, clr;
    calc_exp();
    raw = {per_req, ext_pin, (ext_sel ? port_pin : ext_pin), trap_req, undef_req, nmi_req};
    clr = '0;
    if (e_irq && irq_ack) clr[e_id] = 1'b1;
    if (e_srv && srv_ack) clr[e_sid] = 1'b1;
    @(posedge clk);
    m_pend = (m_pend & ~clr) | (raw & ~m_prev);
    m_prev = raw;
    if (reg_we) begin
      if (reg_addr) m_redir = reg_wdata; else m_mask = reg_wdata;
    end
    m_gie = gie_clr ? 1'b0 : (gie_set ? 1'b1 : m_gie);
    m_tse = tse_clr ? 1'b0 : (tse_set ? 1'b1 : m_tse);
    @(negedge clk);
    {reg_we, gie_set, gie_clr, tse_set, tse_clr, irq_ack, srv_ack} = '0;
  endtask

  task automatic wr(logic a, logic [NMASK-1:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; cycle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp("R1"); reg_addr = 1; cmp("R1"); reg_addr = 0;

    wr(0, '1); cmp("R5");
    per_req[0] = 1; cycle(); cmp("R3");
    gie_set = 1; cycle(); cmp("R4");
    cycle(); cmp("R6");
    gie_set = 1; gie_clr = 1; cycle(); cmp("R4");
    gie_set = 1; cycle(); per_req[0] = 0;
    irq_ack = 1; cycle(); cmp("R7");

    wr(0, '0); nmi_req = 1; trap_req = 1; cycle(); cmp("R2");
    nmi_req = 0; trap_req = 0; irq_ack = 1; cycle(); cmp("R2");
    undef_req = 1; irq_ack = 1; cycle(); undef_req = 0; cmp("R7");
    irq_ack = 1; cycle(); cmp("R7");

    wr(0, '1);
    ext_sel = 0; ext_pin = 1; cycle(); cmp("R8"); cmp("R9");
    ext_pin = 0; irq_ack = 1; cycle(); cmp("R9");
    ext_sel = 1; cmp("R9");
    irq_ack = 1; cycle(); irq_ack = 0;
    port_pin = 1; cycle(); cmp("R8");
    irq_ack = 1; cycle(); port_pin = 0; cmp("R8");

    per_req = 8'h0C; cycle(); per_req = 0; cmp("R12");
    wr(1, NMASK'(10'h020)); cmp("R11");
    tse_set = 1; cycle(); cmp("R10");
    srv_ack = 1; cycle(); cmp("R10");
    tse_set = 1; tse_clr = 1; cycle(); cmp("R10");
    per_req[2] = 1; cycle(); per_req[2] = 0; cmp("R11");

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom(n == 0 ? 32'd1234 : 32'd0);
      r = $urandom();
      nmi_req   = (r[3:0] == 0);
      undef_req = (r[7:4] == 0);
      trap_req  = (r[11:8] == 0);
      per_req   = per_req ^ NPER'($urandom() & $urandom());
      ext_pin   = r[12] ^ ext_pin ? r[13] : ext_pin;
      port_pin  = r[14] & r[15];
      if (r[19:16] == 0) ext_sel = ~ext_sel;
      reg_addr  = r[20];
      reg_we    = (r[24:21] == 0);
      reg_wdata = NMASK'($urandom());
      gie_set   = (r[27:25] == 0);
      gie_clr   = (r[30:28] == 0);
      r = $urandom();
      tse_set   = (r[2:0] == 0);
      tse_clr   = (r[5:3] == 0);
      irq_ack   = r[6];
      srv_ack   = r[7];
      cmp("R12");
      cycle();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule